// File: doc/BRIEF.md
# K-line Response Frame Receiver

This block sits behind a byte-level UART on a diagnostic K-line. It turns the received bytes into framed response messages. Each frame starts with a header of fixed length. The final header byte says how many data bytes follow. After the data comes one checksum byte, which is the sum of every earlier byte of the frame taken modulo 256. The block passes each accepted byte straight through with a one-cycle delay. It marks the first byte of a frame as start-of-frame and the checksum byte as end-of-frame. On the end-of-frame byte it also gives a verdict: good or bad checksum.

The header length is a parameter. So is the longest silence allowed between two bytes of one frame. If the line stays quiet longer than that, part-way through a frame, the block drops the partial frame. The next byte then starts a new frame. Parsing the service identifier and reconstructing the UART bits are left to neighbouring logic.

Top module: `kline_resp_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it, all outputs are 0.
- R2: A byte accepted with `rx_valid` high appears on `fr_data` with `fr_valid` high exactly one clock later. `fr_valid` is low in every cycle that follows a clock with no accepted byte.
- R3: `fr_sof` is high with the first byte of a frame. That is the first byte after reset, after a completed frame, or after an aborted frame. It is low for every other byte.
- R4: A frame is `HDR_LEN` header bytes, then N data bytes, then one checksum byte. N is the unsigned value of header byte `HDR_LEN-1` (counting from 0). `fr_eof` is high only with the checksum byte.
- R5: A length byte of 0 still needs a checksum byte, so the frame is `HDR_LEN+1` bytes long.
- R6: With the checksum byte, `fr_good` is high when that byte equals the modulo-256 sum of all earlier bytes of the frame.
- R7: With the checksum byte, `fr_bad` is high when the sum does not match. `fr_good` and `fr_bad` are never both high, and both are low outside the checksum byte.
- R8: Suppose a frame is in progress (at least one byte received, checksum not yet received) and `GAP_CYCLES` consecutive clocks pass with no accepted byte. The partial frame is then discarded, and the next byte is a start-of-frame. A gap of `GAP_CYCLES-1` clocks keeps the frame intact.
- R9: A byte arriving on the clock right after a checksum byte starts a new frame. No idle cycle is required between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| fr_valid | output | 1 | Output byte is valid |
| fr_data | output | 8 | Frame byte, delayed one clock |
| fr_sof | output | 1 | First byte of a frame |
| fr_eof | output | 1 | Checksum byte, the last of a frame |
| fr_good | output | 1 | Checksum matched (with `fr_eof`) |
| fr_bad | output | 1 | Checksum mismatched (with `fr_eof`) |

## Verification
The bound checker covers the properties that hold on every cycle. It checks the one-cycle pass-through of data and valid, that the markers and verdicts only appear on valid bytes, that the verdict is one-hot on the end-of-frame byte, and that start and end never coincide. Some behaviour depends on the length byte, the running sum and the silence between bytes. That includes where a frame ends, which verdict it gets, and whether a gap aborts it. Only the bench shows these, by sweeping length values with correct and corrupted checksums and by placing gaps of exactly `GAP_CYCLES-1` and `GAP_CYCLES` idle clocks at several positions in a frame.

// File: rtl/krx_pkg.sv
package krx_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } krx_state_e;
endpackage

// File: rtl/krx_gap_timer.sv
module krx_gap_timer #(
    parameter int GAP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic byte_seen,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        expired = 1'b0;
        if (!armed || byte_seen) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            expired   = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/krx_sum_acc.sv
module krx_sum_acc
    import krx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  add,
    input  byte_t data,
    output byte_t sum
);
    typedef struct packed {
        byte_t acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr)      acc_d.acc = '0;
        else if (add) acc_d.acc = acc_q.acc + data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum = acc_q.acc;
endmodule

// File: rtl/krx_frame_fsm.sv
module krx_frame_fsm
    import krx_pkg::*;
#(
    parameter int HDR_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  byte_t run_sum,
    input  logic  gap_expired,
    output logic  mid_frame,
    output logic  sum_clr,
    output logic  sum_add,
    output logic  o_valid,
    output byte_t o_data,
    output logic  o_sof,
    output logic  o_eof,
    output logic  o_good,
    output logic  o_bad
);
    localparam int IDX_W = $clog2(HDR_LEN + 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_LEN - 1);

    typedef struct packed {
        krx_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [8:0]       remain;
        logic             vld;
        byte_t            dat;
        logic             sof;
        logic             eof;
        logic             good;
        logic             bad;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.vld  = 1'b0;
        fsm_d.sof  = 1'b0;
        fsm_d.eof  = 1'b0;
        fsm_d.good = 1'b0;
        fsm_d.bad  = 1'b0;
        sum_clr    = 1'b0;
        sum_add    = 1'b0;

        if (gap_expired) begin
            fsm_d.st     = ST_HEAD;
            fsm_d.idx    = '0;
            fsm_d.remain = '0;
            sum_clr      = 1'b1;
        end else if (in_valid) begin
            fsm_d.vld = 1'b1;
            fsm_d.dat = in_byte;
            if (fsm_q.st == ST_HEAD) begin
                sum_add   = 1'b1;
                fsm_d.sof = (fsm_q.idx == '0);
                if (fsm_q.idx == HDR_LAST) begin
                    fsm_d.st     = ST_BODY;
                    fsm_d.idx    = '0;
                    fsm_d.remain = {1'b0, in_byte} + 9'd1;
                end else begin
                    fsm_d.idx = fsm_q.idx + 1'b1;
                end
            end else if (fsm_q.remain == 9'd1) begin
                fsm_d.eof    = 1'b1;
                fsm_d.good   = (in_byte == run_sum);
                fsm_d.bad    = (in_byte != run_sum);
                fsm_d.st     = ST_HEAD;
                fsm_d.remain = '0;
                sum_clr      = 1'b1;
            end else begin
                fsm_d.remain = fsm_q.remain - 9'd1;
                sum_add      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign mid_frame = (fsm_q.st == ST_BODY) || (fsm_q.idx != '0);
    assign o_valid   = fsm_q.vld;
    assign o_data    = fsm_q.dat;
    assign o_sof     = fsm_q.sof;
    assign o_eof     = fsm_q.eof;
    assign o_good    = fsm_q.good;
    assign o_bad     = fsm_q.bad;
endmodule

// File: rtl/kline_resp_rx.sv
module kline_resp_rx
    import krx_pkg::*;
#(
    parameter int HDR_LEN    = 4,
    parameter int GAP_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       fr_valid,
    output logic [7:0] fr_data,
    output logic       fr_sof,
    output logic       fr_eof,
    output logic       fr_good,
    output logic       fr_bad
);
    logic  mid_frame;
    logic  gap_expired;
    logic  sum_clr;
    logic  sum_add;
    byte_t run_sum;

    krx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (mid_frame),
        .byte_seen (rx_valid),
        .expired   (gap_expired)
    );

    krx_sum_acc u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .add   (sum_add),
        .data  (rx_data),
        .sum   (run_sum)
    );

    krx_frame_fsm #(.HDR_LEN(HDR_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_valid),
        .in_byte     (rx_data),
        .run_sum     (run_sum),
        .gap_expired (gap_expired),
        .mid_frame   (mid_frame),
        .sum_clr     (sum_clr),
        .sum_add     (sum_add),
        .o_valid     (fr_valid),
        .o_data      (fr_data),
        .o_sof       (fr_sof),
        .o_eof       (fr_eof),
        .o_good      (fr_good),
        .o_bad       (fr_bad)
    );
endmodule

// File: rtl/krx_checker.sv
module krx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       fr_valid,
    input logic [7:0] fr_data,
    input logic       fr_sof,
    input logic       fr_eof,
    input logic       fr_good,
    input logic       fr_bad
);
    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> fr_valid) else $error("valid not forwarded"); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fr_valid) else $error("spurious valid"); // R2
    AST_DATA_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fr_data == $past(rx_data))) else $error("data mismatch"); // R2
    AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fr_sof |-> fr_valid) else $error("sof without valid"); // R3
    AST_EOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fr_eof |-> (fr_valid && !fr_sof)) else $error("bad eof"); // R4
    AST_VERDICT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        fr_eof |-> $countones({fr_good, fr_bad}) == 1) else $error("verdict"); // R7
    AST_VERDICT_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_good || fr_bad) |-> fr_eof) else $error("verdict off eof"); // R7
    AST_FRAME_START_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_eof && rx_valid) |=> fr_sof) else $error("no new frame"); // R9
endmodule

bind kline_resp_rx krx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .fr_valid (fr_valid),
    .fr_data  (fr_data),
    .fr_sof   (fr_sof),
    .fr_eof   (fr_eof),
    .fr_good  (fr_good),
    .fr_bad   (fr_bad)
);

// File: tb/sim_kline_resp_rx.sv
`timescale 1ns/1ps
module sim_kline_resp_rx;
    localparam int HDR = 3;
    localparam int GAP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       fr_valid, fr_sof, fr_eof, fr_good, fr_bad;
    logic [7:0] fr_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    kline_resp_rx #(.HDR_LEN(HDR), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .fr_valid(fr_valid), .fr_data(fr_data), .fr_sof(fr_sof),
        .fr_eof(fr_eof), .fr_good(fr_good), .fr_bad(fr_bad)
    );

    task automatic chk(input logic [12:0] act, input logic [12:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (vld,sof,eof,good,bad,data)", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] outs();
        return {fr_valid, fr_sof, fr_eof, fr_good, fr_bad, fr_data};
    endfunction

    // Drive one byte, then check outputs one clock later.
    task automatic push(input logic [7:0] b, input logic s, input logic e,
                        input logic g, input logic x, input string tag);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(outs(), {1'b1, s, e, g, x, b}, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({fr_valid, fr_sof, fr_eof, fr_good, fr_bad}, 5'b0, "R2 idle");
        end
    endtask

    // Full frame: length byte len, optional checksum corruption, gap between bytes.
    task automatic send_frame(input int len, input int seed, input bit corrupt,
                              input int gap, input string sof_tag);
        logic [7:0] sum = '0;
        logic [7:0] b;
        for (int i = 0; i < HDR; i++) begin
            b = (i == HDR - 1) ? 8'(len) : 8'(seed * 7 + i * 13 + 1);
            push(b, i == 0, 1'b0, 1'b0, 1'b0, (i == 0) ? sof_tag : "R4 header");
            sum += b;
            idle(gap);
        end
        for (int j = 0; j < len; j++) begin
            b = 8'(seed + j * 29 + 5);
            push(b, 1'b0, 1'b0, 1'b0, 1'b0, "R4 data");
            sum += b;
            idle(gap);
        end
        b = corrupt ? (sum ^ 8'(1 << (seed % 8))) : sum;
        push(b, 1'b0, 1'b1, !corrupt, corrupt,
             corrupt ? "R7 bad checksum" : (len == 0 ? "R5 empty" : "R6 good checksum"));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        chk(outs(), 13'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs(), 13'b0, "R1 after reset");
        idle(3 * GAP);

        // R4 R5 R6 R7: sweep of lengths, good and bad checksums
        for (int len = 0; len < 14; len++) begin
            send_frame(len, len, 1'b0, len % 3, "R3 sof");
            idle(1);
            send_frame(len, len + 40, 1'b1, 0, "R3 sof");
            idle(2);
        end
        send_frame(255, 9, 1'b0, 0, "R3 sof");
        send_frame(255, 10, 1'b1, 0, "R9 back-to-back");
        idle(1);

        // R9: several frames with no gap at all
        for (int k = 0; k < 4; k++) send_frame(k, k + 90, k[0], 0, "R9 back-to-back");
        idle(2);

        // R8: gap of GAP-1 keeps the frame, at every header and body position
        for (int pos = 1; pos < HDR + 2; pos++) begin
            s = '0;
            for (int i = 0; i < HDR + 2; i++) begin
                logic [7:0] b;
                b = (i == HDR - 1) ? 8'd2 : 8'(i * 17 + pos);
                push(b, i == 0, 1'b0, 1'b0, 1'b0, "R8 keep");
                s += b;
                if (i == pos - 1) idle(GAP - 1);
            end
            push(s, 1'b0, 1'b1, 1'b1, 1'b0, "R8 frame intact");
            idle(1);
        end

        // R8: gap of GAP aborts, next byte starts a frame that completes normally
        for (int pos = 1; pos < HDR + 2; pos++) begin
            for (int i = 0; i < pos; i++) begin
                logic [7:0] b;
                b = (i == HDR - 1) ? 8'd2 : 8'(i * 11 + pos);
                push(b, i == 0, 1'b0, 1'b0, 1'b0, "R8 partial");
            end
            idle(GAP);
            send_frame(pos, pos + 60, 1'b0, 0, "R8 sof after abort");
            idle(1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule